// File: doc/BRIEF.md
# Clock Generator Configuration Slave (two-wire block access)

This block is the serial configuration front end of a multi-output clock generator. A host on a two-wire I2C bus at standard-mode rates (100 kbit/s or slower) writes and reads six 8-bit configuration registers. The block recovers SCL and SDA by oversampling them with its own clock. It detects START and STOP conditions, decodes the device address, and acknowledges bytes by pulling SDA low through an open-drain enable. The register contents are driven onto parallel outputs that steer the rest of the clock chip.

Every transfer has the block format. In a write, the host sends a command code and a byte count, and the block acknowledges and discards both. The data bytes that follow fill registers 0 to 5 in order. In a read, the block first returns a byte count and then registers 0 to 5 in order. Every START moves the access back to register 0.

Register 0 holds the frequency controls. One bit selects where the frequency-select code comes from. The code is either five bits held in the register itself, or five frequency-select pins that are sampled once when reset is released. Registers 1 to 5 hold per-output clock enables.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, register 0 is 0x00 and registers 1 to 5 are 0xFF. So `clk_en_o` is all ones, `spread_en_o`, `tristate_o` and `fsel_override_o` are 0, and `sda_oe_o` is 0 (SDA released).
- R2: The value on `fs_pins_i` is captured in the first clock cycle after reset is released and then held. Later changes on the pins have no effect on `fsel_code_o`.
- R3: The 8-bit write address 0xD2 and read address 0xD3 are acknowledged. Any other address is not acknowledged, and every byte that follows it, up to the next START, is ignored: no acknowledge and no register change.
- R4: In a write, the first two bytes after the address (command code, byte count) are acknowledged and discarded. Data bytes then go to registers 0, 1, 2 and onward, and each is acknowledged. `clk_en_o[8*k-1 -: 8]` shows register k for k = 1..5.
- R5: A STOP after any complete data byte keeps every byte already stored. A data byte that is cut short by a STOP is discarded.
- R6: Data bytes that arrive after register 5 has been written are acknowledged and discarded.
- R7: The register pointer goes back to register 0 on every START.
- R8: Register 0 bits: bit 3 = 1 makes `fsel_code_o` equal to {bit2, bit7, bit6, bit5, bit4} (bit 2 is the MSB), and bit 3 = 0 makes it the captured pin code. Bit 1 drives `spread_en_o`, bit 0 drives `tristate_o`, and bit 3 drives `fsel_override_o`.
- R9: In a read, the block sends the byte count 6 and then registers 0 to 5. Each byte goes out MSB first, and a new byte starts only after the host acknowledges. A host NACK ends the transfer. Bytes requested after register 5 read as 0xFF.
- R10: The block changes `sda_oe_o` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| fs_pins_i | input | 5 | Frequency-select straps, captured after reset |
| fsel_code_o | output | 5 | Active frequency-select code |
| fsel_override_o | output | 1 | Code taken from the register rather than the pins |
| spread_en_o | output | 1 | Spread-spectrum enable |
| tristate_o | output | 1 | Tristate all clock outputs |
| clk_en_o | output | 40 | Per-output enables, registers 5..1 from MSB to LSB |

## Verification
The hardest case to reach from the ports is a byte that is only partly shifted in when a STOP arrives. The host model clocks four bits of a data byte and then makes the SDA low-to-high transition while SCL is high. The bench then reads the registers back to show that nothing beyond the last complete byte was stored. Reads that run past register 5 need a long host read with acknowledges. The one-time pin capture is shown by changing the straps after reset, and by asserting reset a second time with different straps.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/1ps
package clkcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } i2c_state_e;

  // register 0 bit positions
  localparam int unsigned R0_TRI    = 0;
  localparam int unsigned R0_SPREAD = 1;
  localparam int unsigned R0_CMSB   = 2;
  localparam int unsigned R0_OVR    = 3;
  localparam int unsigned FS_W      = 5;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_o = scl_ff[STAGES-1];
  assign sda_o = sda_ff[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_o;
      sda_q <= sda_o;
    end
  end

  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_block_fsm.sv
`timescale 1ns/1ps
module i2c_block_fsm
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned NUM_REGS = 6,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned CNT_W   = $clog2(NUM_REGS + 3)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic [CNT_W-1:0] rd_idx_o,
  input  logic [7:0]       rd_data_i,
  output logic             rd_mode_o,
  output logic             idle_o
);
  localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(2);
  localparam logic [CNT_W-1:0] END_DATA   = CNT_W'(NUM_REGS + 2);
  localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(NUM_REGS + 1);

  i2c_state_e       state_q;
  logic [3:0]       bit_cnt_q;
  logic [7:0]       rx_q, tx_q;
  logic [CNT_W-1:0] byte_cnt_q, tx_idx_q;
  logic             rd_mode_q, host_ack_q;
  logic [CNT_W-1:0] slot;

  assign slot = byte_cnt_q - FIRST_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      byte_cnt_q <= '0;
      tx_idx_q   <= '0;
      rd_mode_q  <= 1'b0;
      host_ack_q <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state_q    <= ST_ADDR;
        bit_cnt_q  <= '0;
        byte_cnt_q <= '0;
        tx_idx_q   <= '0;
        rd_mode_q  <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise_i && bit_cnt_q < 4'd8) begin
              rx_q      <= {rx_q[6:0], sda_s_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              bit_cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (rx_q[7:1] == DEV_ADDR) begin
                  rd_mode_q <= rx_q[0];
                  state_q   <= ST_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                state_q <= ST_ACK;
                if (byte_cnt_q >= FIRST_DATA && byte_cnt_q < END_DATA) begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= slot[IDX_W-1:0];
                  wr_data_o <= rx_q;
                end
                if (byte_cnt_q != END_DATA) byte_cnt_q <= byte_cnt_q + 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (rd_mode_q) begin
                tx_q    <= rd_data_i;
                state_q <= ST_TX;
                if (tx_idx_q != RD_LAST) tx_idx_q <= tx_idx_q + 1'b1;
              end else begin
                state_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (bit_cnt_q == 4'd7) begin
                state_q <= ST_TXACK;
              end else begin
                tx_q      <= {tx_q[6:0], 1'b0};
                bit_cnt_q <= bit_cnt_q + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise_i) begin
              host_ack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (host_ack_q) begin
                tx_q      <= rd_data_i;
                bit_cnt_q <= '0;
                state_q   <= ST_TX;
                if (tx_idx_q != RD_LAST) tx_idx_q <= tx_idx_q + 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = (state_q == ST_ACK) || (state_q == ST_TX && !tx_q[7]);
  assign rd_idx_o  = tx_idx_q;
  assign rd_mode_o = rd_mode_q;
  assign idle_o    = (state_q == ST_IDLE);
endmodule

// File: rtl/clkcfg_regs.sv
`timescale 1ns/1ps
module clkcfg_regs
  import clkcfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 6,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned CNT_W   = $clog2(NUM_REGS + 3),
  localparam int unsigned EN_W    = (NUM_REGS - 1) * 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic [CNT_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  input  logic [FS_W-1:0]  fs_pins_i,
  output logic [FS_W-1:0]  fs_latched_o,
  output logic             fs_valid_o,
  output logic [7:0]       reg0_o,
  output logic [EN_W-1:0]  en_o
);
  logic [7:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RST_VAL = (i == 0) ? 8'h00 : 8'hFF;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    regs_q[i] <= RST_VAL;
      else if (wr_en_i && wr_idx_i == IDX_W'(i))      regs_q[i] <= wr_data_i;
    end
    if (i > 0) begin : g_en
      assign en_o[(i-1)*8 +: 8] = regs_q[i];
    end
  end

  assign reg0_o = regs_q[0];

  // stream index 0 is the byte count, 1..NUM_REGS the registers
  always_comb begin
    rd_data_o = 8'hFF;
    if (rd_idx_i == '0) begin
      rd_data_o = 8'(NUM_REGS);
    end else begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (rd_idx_i == CNT_W'(k + 1)) rd_data_o = regs_q[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_latched_o <= '0;
      fs_valid_o   <= 1'b0;
    end else if (!fs_valid_o) begin
      fs_latched_o <= fs_pins_i;
      fs_valid_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/clkcfg_i2c_slave.sv
`timescale 1ns/1ps
module clkcfg_i2c_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned NUM_REGS    = 6,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS),
  localparam int unsigned CNT_W      = $clog2(NUM_REGS + 3),
  localparam int unsigned EN_W       = (NUM_REGS - 1) * 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  input  logic [FS_W-1:0] fs_pins_i,
  output logic [FS_W-1:0] fsel_code_o,
  output logic            fsel_override_o,
  output logic            spread_en_o,
  output logic            tristate_o,
  output logic [EN_W-1:0] clk_en_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, rd_mode, bus_idle, fs_valid;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data, rd_data, reg0;
  logic [CNT_W-1:0] rd_idx;
  logic [FS_W-1:0]  fs_latched;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_block_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
    .clk_i, .rst_ni,
    .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .sda_oe_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .rd_idx_o(rd_idx), .rd_data_i(rd_data),
    .rd_mode_o(rd_mode), .idle_o(bus_idle)
  );

  clkcfg_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .fs_pins_i, .fs_latched_o(fs_latched), .fs_valid_o(fs_valid),
    .reg0_o(reg0), .en_o(clk_en_o)
  );

  always_comb begin
    fsel_override_o = reg0[R0_OVR];
    spread_en_o     = reg0[R0_SPREAD];
    tristate_o      = reg0[R0_TRI];
    fsel_code_o     = reg0[R0_OVR] ? {reg0[R0_CMSB], reg0[7:4]} : fs_latched;
  end
endmodule

// File: rtl/clkcfg_i2c_checker.sv
`timescale 1ns/1ps
module clkcfg_i2c_checker #(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned EN_W     = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s,
  input logic             sda_oe_o,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             rd_mode,
  input logic             bus_idle,
  input logic             fs_valid,
  input logic [4:0]       fs_latched,
  input logic [EN_W-1:0]  clk_en_o,
  input logic             spread_en_o,
  input logic             tristate_o
);
  AST_FS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_valid && $past(fs_valid)) |-> $stable(fs_latched)); // R2

  AST_NO_WRITE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !rd_mode); // R9

  AST_WR_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (32'(wr_idx) < NUM_REGS)); // R6

  AST_REGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> ($stable(clk_en_o) && $stable(spread_en_o) && $stable(tristate_o))); // R4

  AST_NO_WRITE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_idle |=> !wr_en); // R3

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s); // R10
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_checker #(
  .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .EN_W(EN_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .wr_en(wr_en), .wr_idx(wr_idx), .rd_mode(rd_mode), .bus_idle(bus_idle),
  .fs_valid(fs_valid), .fs_latched(fs_latched), .clk_en_o(clk_en_o),
  .spread_en_o(spread_en_o), .tristate_o(tristate_o)
);

// File: tb/tb_clkcfg_i2c_slave.sv
`timescale 1ns/1ps
module tb_clkcfg_i2c_slave;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1;
  logic [4:0] fs_pins = 5'b01101;
  logic sda_oe, ovr, spr, tri_o, sda_bus;
  logic [4:0] code;
  logic [39:0] en;

  assign sda_bus = sda_h & ~sda_oe;

  always #2.5 clk = ~clk;

  clkcfg_i2c_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .fs_pins_i(fs_pins), .fsel_code_o(code),
    .fsel_override_o(ovr), .spread_en_o(spr), .tristate_o(tri_o),
    .clk_en_o(en)
  );

  int total = 0, bad = 0, r10_viol = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0;
  logic [7:0] wbuf [0:9];
  logic [7:0] rbuf [0:9];
  logic ack_seen;

  // {r5,r4,r3,r2,r1,r0}, expected {code,ovr,spr,tri} with pins latched as 0x0D
  localparam logic [47:0] VEC_REGS [4] = '{
    48'h11_22_33_44_55_5C, 48'hF0_0F_AA_55_C3_A2,
    48'h00_00_00_00_00_FB, 48'h80_40_20_10_08_3D};
  localparam logic [7:0] VEC_EXP [4] = '{8'hAC, 8'h6A, 8'h7F, 8'h9D};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_h = 1'b1; scl = 1'b1; wq(); sda_h = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_h = 1'b0; wq(); scl = 1'b1; wq(); sda_h = 1'b1; wq(); wq();
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_h = 1'b1; wq(); scl = 1'b1; wq(); acked = ~sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl = 1'b1; wq(); b = {b[6:0], sda_bus}; wq(); scl = 1'b0;
    end
    wq(); sda_h = ~give_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); sda_h = 1'b1;
  endtask

  // write n data bytes from wbuf after command and count; acks checked
  task automatic write_regs(input int n, input string req);
    i2c_start();
    send_byte(8'hD2, ack_seen); check({req, " R3 addr ack"}, ack_seen, 1'b1);
    send_byte(8'hA5, ack_seen); check({req, " R4 cmd ack"}, ack_seen, 1'b1);
    send_byte(8'h3C, ack_seen); check({req, " R4 count ack"}, ack_seen, 1'b1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack_seen); check({req, " data ack"}, ack_seen, 1'b1);
    end
    i2c_stop();
  endtask

  // read n stream bytes into rbuf, NACK on the last
  task automatic read_stream(input int n);
    i2c_start();
    send_byte(8'hD3, ack_seen); check("R3 read addr ack", ack_seen, 1'b1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    i2c_stop();
  endtask

  always @(negedge clk) begin
    if (rst_n && scl && sda_oe !== prev_oe) r10_viol++;
    prev_oe <= sda_oe;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 clk_en reset", en, 40'hFF_FFFF_FFFF);
    check("R1 spread reset", spr, 1'b0);
    check("R1 tristate reset", tri_o, 1'b0);
    check("R1 override reset", ovr, 1'b0);
    check("R1 sda released", sda_oe, 1'b0);
    check("R2 pin code latched", code, 5'h0D);
    fs_pins = 5'h1F;
    repeat (4) @(negedge clk);
    check("R2 pin change ignored", code, 5'h0D);

    // table of register patterns: write, decode, read back (R4 R7 R8 R9)
    for (int e = 0; e < 4; e++) begin
      for (int k = 0; k < 6; k++) wbuf[k] = VEC_REGS[e][8*k +: 8];
      write_regs(6, "R4 vec");
      check("R8 code", code, VEC_EXP[e][7:3]);
      check("R8 override", ovr, VEC_EXP[e][2]);
      check("R8 spread", spr, VEC_EXP[e][1]);
      check("R8 tristate", tri_o, VEC_EXP[e][0]);
      check("R4 clk_en layout", en, VEC_REGS[e][47:8]);
      read_stream(7);
      check("R9 byte count", rbuf[0], 8'd6);
      for (int k = 0; k < 6; k++) check("R9 readback", rbuf[k+1], VEC_REGS[e][8*k +: 8]);
    end

    // R3 foreign address: no ack, following byte ignored
    i2c_start();
    send_byte(8'hA0, ack_seen); check("R3 foreign addr nack", ack_seen, 1'b0);
    send_byte(8'h00, ack_seen); check("R3 foreign data nack", ack_seen, 1'b0);
    i2c_stop();
    check("R3 regs untouched", en, 40'h80_40_20_10_08);
    check("R3 reg0 untouched", {spr, tri_o, code}, {1'b0, 1'b1, 5'h13});

    // R5 short write keeps complete byte, R7 pointer restarts at reg0
    wbuf[0] = 8'h02;
    write_regs(1, "R5 short");
    check("R5 short write reg0", {ovr, spr, tri_o}, 3'b010);
    check("R5 reg1 kept", en, 40'h80_40_20_10_08);
    check("R2 pins held", code, 5'h0D);
    i2c_start();
    send_byte(8'hD2, ack_seen);
    send_byte(8'h00, ack_seen);
    send_byte(8'h00, ack_seen);
    send_byte(8'h01, ack_seen); check("R7 reg0 ack", ack_seen, 1'b1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    i2c_stop();
    check("R7 reg0 rewritten", {spr, tri_o}, 2'b01);
    check("R5 partial byte dropped", en, 40'h80_40_20_10_08);

    // R6 extra bytes acked and dropped
    wbuf[0] = 8'h00; wbuf[1] = 8'h01; wbuf[2] = 8'h02; wbuf[3] = 8'h03;
    wbuf[4] = 8'h04; wbuf[5] = 8'h05; wbuf[6] = 8'hEE; wbuf[7] = 8'hDD;
    write_regs(8, "R6 overrun");
    check("R6 regs after overrun", en, 40'h05_04_03_02_01);
    check("R6 reg0 after overrun", {ovr, spr, tri_o}, 3'b000);

    // R9 read past the end, then short read
    read_stream(9);
    check("R9 count", rbuf[0], 8'd6);
    check("R9 reg0", rbuf[1], 8'h00);
    check("R9 reg5", rbuf[6], 8'h05);
    check("R9 past end a", rbuf[7], 8'hFF);
    check("R9 past end b", rbuf[8], 8'hFF);
    read_stream(2);
    check("R9 short read count", rbuf[0], 8'd6);
    check("R9 short read reg0", rbuf[1], 8'h00);
    check("R9 sda released after nack", sda_oe, 1'b0);
    wbuf[0] = 8'h08;
    write_regs(1, "R9 bus free");
    check("R8 override zero code", {ovr, code}, {1'b1, 5'h00});

    // R2 second reset with new straps, R1 values restored
    rst_n = 1'b0; fs_pins = 5'h12;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 new straps", code, 5'h12);
    check("R1 clk_en after reset", en, 40'hFF_FFFF_FFFF);
    check("R1 reg0 after reset", {ovr, spr, tri_o}, 3'b000);

    check("R10 drive change with scl low", r10_viol, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule